// File: doc/BRIEF.md
# Manchester Lighting-Bus Frame Transmitter

This block drives one half-duplex lighting-control bus line with a Manchester-coded frame. A frame is one, two or three bytes. The first byte comes in on a byte-wide valid/ready port together with a length tag. Any further bytes come in on the same port while the frame is already going out. On the line the frame is a start bit, then every byte most significant bit first, then two idle bit periods that act as stop bits.

Timing comes from a clock-enable input, `half_tick`, which marks every half-bit boundary. The bit rate is therefore chosen outside the block; the nominal half-bit is about 416.7 µs, so a full bit is about 833.3 µs. One byte is buffered behind the shifter, so a byte that arrives while the previous byte is still shifting follows it with no gap. If a byte owed to the frame has not arrived when the shifter runs dry, the frame is cut short and an underrun flag is raised. A `busy` level and a one-cycle `done` pulse give the frame status to the surrounding logic.

Top module: `mlb_frame_tx`

## Requirements
- R1: Each data bit lasts two ticks. A logic 1 drives the line low for the first half and high for the second half. A logic 0 drives it high, then low. So the line changes level at the middle of every bit, and changes at a bit boundary only when two equal bits follow each other.
- R2: The first tick after a frame is accepted drives the line low, and the second tick drives it high. This start bit is a logic 1 and comes before any data.
- R3: The bits of each byte go out most significant bit first (bit 7 first, bit 0 last).
- R4: `in_len` is sampled with the first byte and sets the frame length: 1, 2 or 3 bytes for the values 1, 2 and 3. The value 0 is treated as 1.
- R5: A following byte accepted while the current byte is still shifting starts on the tick right after the current byte's last half-bit, with no extra half-bit in between.
- R6: After the last data half-bit the line stays high for four ticks, which are the two stop periods. The tick that closes them makes `done` high for exactly one clock and drops `busy` on that same edge.
- R7: After reset, and whenever no frame is in progress, `line` is high, `busy` is low, `done` is low and `in_ready` is high. Reset also clears `underrun`.
- R8: If the shifter empties while the frame still owes a byte and no byte is buffered, the stop periods follow at once and `underrun` goes high. `underrun` stays high until the next frame is accepted.
- R9: `line` changes only on clock edges where `half_tick` is high. Between ticks, including the time between accepting a frame and its first tick, `line` holds its value.
- R10: During a frame, `in_ready` is high only while the frame still owes a byte and the one-byte buffer is empty. Bytes beyond the declared length are not accepted and do not change the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| half_tick | input | 1 | Clock enable, one pulse per half-bit period |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Byte is taken on this cycle when `in_valid` is high |
| in_data | input | 8 | Frame byte |
| in_len | input | 2 | Frame length tag, sampled with the first byte (0 or 1: one byte, 2: two bytes, 3: three bytes) |
| line | output | 1 | Manchester-coded bus level, high when idle |
| busy | output | 1 | High from acceptance of the first byte until the frame ends |
| done | output | 1 | One-cycle pulse at the end of the second stop period |
| underrun | output | 1 | A declared byte was missing when the shifter emptied |

## Verification
`line`, `busy`, `done` and `underrun` are registered. Each one takes its new value on the same rising edge that sees `half_tick` high, and `busy` also rises on the edge that accepts the first byte. `in_ready` is combinational from the state and holds steady between edges. The bench raises `half_tick` for one clock, then samples on the next falling edge, one half cycle after the edge that acted on the tick, and compares against a half-bit sequence built from the frame bytes. It also leaves gaps of several clocks with no tick, to confirm the line holds between ticks.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/mlb_hold.sv
module mlb_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic              valid_q, valid_n;
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    valid_n = valid_q;
    data_n  = data_q;
    if (push) begin
      valid_n = 1'b1;
      data_n  = push_data;
    end else if (pop) begin
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_n;
      data_q  <= data_n;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R5: a buffered byte is neither lost nor altered before it is taken
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !pop) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/mlb_shifter.sv
module mlb_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              last
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (load) begin
      sh_n  = load_data;
      cnt_n = CNT_W'(DATA_W - 1);
    end else if (shift) begin
      sh_n  = {sh_q[DATA_W-2:0], 1'b0};
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign cur_bit  = sh_q[DATA_W-1];
  assign next_bit = sh_q[DATA_W-2];
  assign last     = (cnt_q == '0);

  // R3: a byte is never reloaded and advanced on the same edge
  a_r3_load_xor_shift: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);
endmodule

// File: rtl/mlb_frame_tx.sv
module mlb_frame_tx #(
  parameter int DATA_W      = 8,
  parameter int MAX_BYTES   = 3,
  parameter int STOP_HALVES = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 half_tick,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [DATA_W-1:0]                    in_data,
  input  logic [$clog2(MAX_BYTES+1)-1:0]       in_len,
  output logic                                 line,
  output logic                                 busy,
  output logic                                 done,
  output logic                                 underrun
);
  import mlb_pkg::*;

  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int SC_W  = $clog2(STOP_HALVES);

  tx_state_e         state_q, state_n;
  logic              ph_q, ph_n;
  logic              line_q, line_n;
  logic [LEN_W-1:0]  left_q, left_n;
  logic [SC_W-1:0]   stop_q, stop_n;
  logic              udr_q, udr_n;
  logic              done_q, done_n;

  logic              sh_load, sh_shift, sh_cur, sh_next, sh_last;
  logic [DATA_W-1:0] sh_ld_data;
  logic              hold_push, hold_pop, hold_valid;
  logic [DATA_W-1:0] hold_data;

  assign in_ready  = (state_q == ST_IDLE) || ((left_q != '0) && !hold_valid);
  assign hold_push = in_valid && in_ready && (state_q != ST_IDLE);

  mlb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(hold_push), .push_data(in_data),
    .pop(hold_pop), .valid(hold_valid), .data(hold_data)
  );

  mlb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_ld_data),
    .shift(sh_shift), .cur_bit(sh_cur), .next_bit(sh_next), .last(sh_last)
  );

  always_comb begin
    state_n    = state_q;
    ph_n       = ph_q;
    line_n     = line_q;
    left_n     = left_q;
    stop_n     = stop_q;
    udr_n      = udr_q;
    done_n     = 1'b0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    sh_ld_data = in_data;
    hold_pop   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          sh_load = 1'b1;
          left_n  = (in_len == '0) ? '0 : LEN_W'(in_len - 1'b1);
          udr_n   = 1'b0;
          state_n = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (half_tick) begin
          line_n  = 1'b0;
          ph_n    = 1'b0;
          state_n = ST_START;
        end
      end
      ST_START: begin
        if (half_tick) begin
          if (!ph_q) begin
            line_n = 1'b1;
            ph_n   = 1'b1;
          end else begin
            line_n  = ~sh_cur;
            ph_n    = 1'b0;
            state_n = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (half_tick) begin
          if (!ph_q) begin
            line_n = sh_cur;
            ph_n   = 1'b1;
          end else if (!sh_last) begin
            sh_shift = 1'b1;
            line_n   = ~sh_next;
            ph_n     = 1'b0;
          end else if ((left_q != '0) && hold_valid) begin
            sh_load    = 1'b1;
            sh_ld_data = hold_data;
            hold_pop   = 1'b1;
            left_n     = left_q - 1'b1;
            line_n     = ~hold_data[DATA_W-1];
            ph_n       = 1'b0;
          end else begin
            udr_n   = (left_q != '0);
            left_n  = '0;
            line_n  = 1'b1;
            stop_n  = '0;
            state_n = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (half_tick) begin
          if (stop_q == SC_W'(STOP_HALVES - 1)) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            stop_n = stop_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      line_q  <= 1'b1;
      left_q  <= '0;
      stop_q  <= '0;
      udr_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ph_q    <= ph_n;
      line_q  <= line_n;
      left_q  <= left_n;
      stop_q  <= stop_n;
      udr_q   <= udr_n;
      done_q  <= done_n;
    end
  end

  assign line     = line_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign underrun = udr_q;

  // R1: every data bit has a level change at its midpoint
  a_r1_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && state_q == ST_DATA && !ph_q) |=> (line_q != $past(line_q)));
  // R2: the first half of the start bit is low
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && state_q == ST_ARMED) |=> !line_q);
  // R6: the end-of-frame pulse lasts one clock
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: the line is high whenever no frame is in progress
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> line_q);
  // R9: the line only moves on a tick
  a_r9_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(line_q));
  // R10: no byte is taken during the stop periods
  a_r10_no_take_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> !in_ready);
endmodule

// File: tb/mlb_frame_tx_test.sv
module mlb_frame_tx_test;
  logic       clk;
  logic       rst_n;
  logic       half_tick;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [1:0] in_len;
  logic       line, busy, done, underrun;

  int n_cmp;
  int n_bad;

  mlb_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_len(in_len), .line(line),
    .busy(busy), .done(done), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic tick_once;
    repeat (2) @(negedge clk);
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; half_tick = 1'b0; in_valid = 1'b0; in_data = '0; in_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset line", line, 1);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R7 reset in_ready", in_ready, 1);
    chk("R7 reset underrun", underrun, 0);
  endtask

  // Sends one frame; nsup bytes are offered, flood keeps in_valid high with junk,
  // gap holds the tick off for a while mid-frame.
  task automatic t_frame(input string name, input logic [1:0] tag, input int nsup,
                         input logic [23:0] bytes, input bit flood, input bit gap);
    logic exp [0:63];
    int len, nsent, nh;
    bit udr;
    len   = (tag == 2'd0) ? 1 : int'(tag);
    nsent = (nsup < len) ? nsup : len;
    udr   = (nsup < len);
    exp[0] = 1'b0;
    exp[1] = 1'b1;
    nh = 2;
    for (int j = 0; j < nsent; j++) begin
      for (int i = 7; i >= 0; i--) begin
        exp[nh]   = ~bytes[23 - 8*j - (7 - i)];
        exp[nh+1] =  bytes[23 - 8*j - (7 - i)];
        nh += 2;
      end
    end
    for (int s = 0; s < 4; s++) begin
      exp[nh] = 1'b1;
      nh++;
    end

    @(negedge clk);
    chk({name, " R7 ready before frame"}, in_ready, 1);
    in_valid = 1'b1; in_data = bytes[23:16]; in_len = tag;
    @(negedge clk);
    in_valid = flood; in_data = 8'hFF;
    chk({name, " R9 busy after accept"}, busy, 1);
    chk({name, " R8 underrun cleared"}, underrun, 0);
    repeat (3) @(negedge clk);
    chk({name, " R9 line holds before first tick"}, line, 1);

    fork
      begin
        int k;
        k = 1;
        while (k < nsent) begin
          @(negedge clk);
          if (in_ready) begin
            in_valid = 1'b1;
            in_data  = bytes[23 - 8*k -: 8];
            @(negedge clk);
            in_valid = 1'b0;
            k++;
          end
        end
      end
      begin
        for (int h = 0; h < nh; h++) begin
          tick_once();
          if (h == 0) chk({name, " R2 start first half"}, line, exp[h]);
          else if (h == 1) chk({name, " R2 start second half"}, line, exp[h]);
          else if (h < nh - 4) chk({name, " R1 R3 R5 data half"}, line, exp[h]);
          else begin
            chk({name, " R6 stop half"}, line, exp[h]);
            chk({name, " R6 busy in stop"}, busy, 1);
            chk({name, " R10 ready low in stop"}, in_ready, 0);
          end
          if (len == 1) chk({name, " R10 ready low one-byte frame"}, in_ready, 0);
          if (flood && h == nh - 4) in_valid = 1'b0;
          if (gap && h == 5) begin
            repeat (6) @(negedge clk);
            chk({name, " R9 line holds without tick"}, line, exp[5]);
          end
        end
        tick_once();
        chk({name, " R6 done pulse"}, done, 1);
        chk({name, " R6 busy falls"}, busy, 0);
        chk({name, " R7 line idle"}, line, 1);
        chk({name, " R8 underrun flag"}, underrun, udr);
        @(negedge clk);
        chk({name, " R6 done single cycle"}, done, 0);
        chk({name, " R8 underrun held"}, underrun, udr);
      end
    join
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    t_reset();
    t_frame("backward", 2'd1, 1, 24'hA50000, 1'b1, 1'b0);
    t_frame("forward2", 2'd2, 2, 24'hFF0000, 1'b0, 1'b1);
    t_frame("forward3", 2'd3, 3, 24'h1234C3, 1'b0, 1'b0);
    t_frame("R4 tag0", 2'd0, 1, 24'h5A0000, 1'b0, 1'b0);
    t_frame("R8 short3", 2'd3, 2, 24'h81E700, 1'b0, 1'b0);
    t_frame("R8 short2", 2'd2, 1, 24'h3C0000, 1'b0, 1'b1);
    t_frame("after underrun", 2'd2, 2, 24'h0F6600, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule